// File: doc/BRIEF.md
# DC Offset Removal Filter with Freezable Estimate

This block sits directly after a decimation filter in a stereo sample path. For each of the two channels it keeps its own estimate of the DC level and subtracts that estimate from every sample that passes through. Samples arrive one at a time with a valid strobe and a channel tag. The corrected sample leaves one clock later with its own strobe and the same tag.

Each estimate is a first-order leaky integrator with fractional precision. A freeze input stops the selected channel's estimate from moving, but the held value is still subtracted from every sample. This supports a system offset calibration: run the block unfrozen until the estimate has settled on the offset of the whole analog path, then assert freeze. From then on the block removes that stored offset and nothing else. The subtraction saturates at the limits of the sample range instead of wrapping.

Top module: `dc_offset_remover`

## Requirements
- R1: `out_valid` is high exactly one clock after a cycle with `in_valid` high, and low one clock after a cycle with `in_valid` low. `out_chan` repeats the `in_chan` of that accepted sample.
- R2: For an accepted sample x on channel c, the output is x − floor(E_c / 2^SHIFT_K). E_c is the estimate of channel c before this sample updates it. E_c is stored with SHIFT_K fractional bits.
- R3: When a sample is accepted with `freeze` low, the estimate of its channel is updated as E_c ← E_c + floor((x·2^SHIFT_K − E_c) / 2^SHIFT_K).
- R4: When a sample is accepted with `freeze` high, the estimate of its channel keeps its value, and that held offset is still subtracted from the output.
- R5: Channel tag 0 is left and 1 is right. A sample on one channel never changes the estimate of the other channel.
- R6: The difference is clamped to the signed DATA_W range. With DATA_W = 24, results below −8388608 give −8388608 and results above 8388607 give 8388607.
- R7: A synchronous active-high reset clears both estimates to zero, and clears `out_valid` and `out_data` to zero.
- R8: Cycles with `in_valid` low leave both estimates unchanged.
- R9: For a constant unfrozen input on one channel, the output magnitude decays toward zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_chan | input | 1 | Channel tag of the input sample (0 left, 1 right) |
| in_data | input | DATA_W | Signed input sample from the decimator |
| freeze | input | 1 | Hold the estimate of the sampled channel |
| out_valid | output | 1 | Output sample strobe |
| out_chan | output | 1 | Channel tag of the output sample |
| out_data | output | DATA_W | Signed, offset-corrected, saturated sample |

## Verification
The bench builds the block with DATA_W = 24 and SHIFT_K = 4. With that shift, an estimate settles within about a hundred samples. This makes it practical to drive an estimate close to full scale, freeze it, and then apply an input of the opposite extreme, which forces both saturation limits. A behavioural model tracks each channel's estimate as a 64-bit integer and is compared on every clock. The stimulus covers idle gaps, frozen runs and a long stretch of random valid, channel and freeze patterns.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/dcr_offset_bank.sv
module dcr_offset_bank #(
  parameter int unsigned DATA_W  = 24,
  parameter int unsigned SHIFT_K = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     upd_en,
  input  logic                     sel,
  input  logic                     hold,
  input  logic signed [DATA_W-1:0] sample,
  output logic signed [DATA_W-1:0] offset
);
  import dcr_pkg::*;

  localparam int unsigned ACC_W = DATA_W + SHIFT_K + 1;

  logic signed [ACC_W-1:0] acc_q [NUM_CH];
  logic signed [ACC_W-1:0] acc_sel;
  logic signed [ACC_W-1:0] x_ext;
  logic signed [ACC_W:0]   diff;
  logic signed [ACC_W:0]   diff_sh;
  logic signed [ACC_W-1:0] step;

  always_comb begin
    acc_sel = acc_q[sel];
    x_ext   = {sample[DATA_W-1], sample, {SHIFT_K{1'b0}}};
    diff    = {x_ext[ACC_W-1], x_ext} - {acc_sel[ACC_W-1], acc_sel};
    diff_sh = diff >>> SHIFT_K;
    step    = diff_sh[ACC_W-1:0];
    offset  = acc_sel[DATA_W+SHIFT_K-1:SHIFT_K];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CH; i++) begin
      if (rst) begin
        acc_q[i] <= '0;
      end else if (upd_en && !hold && (int'(sel) == i)) begin
        acc_q[i] <= acc_q[i] + step;
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R4
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (upd_en && hold && (int'(sel) == g)) |=> $stable(acc_q[g]));
    // R5
    chan_isolation_chk: assert property (@(posedge clk) disable iff (rst)
      (upd_en && (int'(sel) != g)) |=> $stable(acc_q[g]));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!upd_en) |=> $stable(acc_q[g]));
    // R7
    reset_clear_chk: assert property (@(posedge clk)
      rst |=> (acc_q[g] == '0));
  end

endmodule

// File: rtl/dcr_sat_sub.sv
module dcr_sat_sub #(
  parameter int unsigned DATA_W = 24
) (
  input  logic signed [DATA_W-1:0] minuend,
  input  logic signed [DATA_W-1:0] subtrahend,
  output logic signed [DATA_W-1:0] result
);
  localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W:0] wide;

  always_comb begin
    wide = {minuend[DATA_W-1], minuend} - {subtrahend[DATA_W-1], subtrahend};
    if (wide[DATA_W] != wide[DATA_W-1]) begin
      result = wide[DATA_W] ? MIN_V : MAX_V;
    end else begin
      result = wide[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/dc_offset_remover.sv
module dc_offset_remover #(
  parameter int unsigned DATA_W  = 24,
  parameter int unsigned SHIFT_K = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_chan,
  input  logic [DATA_W-1:0] in_data,
  input  logic              freeze,
  output logic              out_valid,
  output logic              out_chan,
  output logic [DATA_W-1:0] out_data
);

  logic signed [DATA_W-1:0] offset;
  logic signed [DATA_W-1:0] corrected;

  dcr_offset_bank #(
    .DATA_W  (DATA_W),
    .SHIFT_K (SHIFT_K)
  ) u_bank (
    .clk    (clk),
    .rst    (rst),
    .upd_en (in_valid),
    .sel    (in_chan),
    .hold   (freeze),
    .sample (in_data),
    .offset (offset)
  );

  dcr_sat_sub #(
    .DATA_W (DATA_W)
  ) u_sub (
    .minuend    (in_data),
    .subtrahend (offset),
    .result     (corrected)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_chan  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_chan <= in_chan;
        out_data <= corrected;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_valid && (out_chan == $past(in_chan))));
  // R1
  valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R6
  no_wrap_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_data[DATA_W-1] && offset[DATA_W-1]) |=> !out_data[DATA_W-1]);
  // R6
  no_wrap_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data[DATA_W-1] && !offset[DATA_W-1]) |=> out_data[DATA_W-1]);
  // R7
  reset_out_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && (out_data == '0)));

endmodule

// File: tb/dc_offset_remover_test.sv
module dc_offset_remover_test;

  localparam int DW = 24;
  localparam int K  = 4;
  localparam longint MAXV = 64'sd8388607;
  localparam longint MINV = -64'sd8388608;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic          in_chan;
  logic [DW-1:0] in_data;
  logic          freeze;
  logic          out_valid;
  logic          out_chan;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  longint acc_m [2];
  longint last_y;
  bit     done = 0;

  always #10 clk = ~clk;

  dc_offset_remover #(.DATA_W(DW), .SHIFT_K(K)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
    .in_data(in_data), .freeze(freeze), .out_valid(out_valid),
    .out_chan(out_chan), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one accepted or idle cycle, compared against the behavioural model
  task automatic step(input bit v, input bit ch, input longint x, input bit frz, input string req);
    longint off, d;
    in_valid = v; in_chan = ch; in_data = x[DW-1:0]; freeze = frz;
    d = 0;
    if (v) begin
      off = acc_m[ch] >>> K;
      d = x - off;
      if (d > MAXV) d = MAXV;
      if (d < MINV) d = MINV;
      if (!frz) acc_m[ch] = acc_m[ch] + (((x <<< K) - acc_m[ch]) >>> K);
    end
    @(negedge clk);
    check(out_valid == v, "R1 valid", longint'(out_valid), longint'(v));
    if (v) begin
      last_y = longint'($signed(out_data));
      check(out_chan == ch, "R1 chan", longint'(out_chan), longint'(ch));
      check(last_y == d, req, last_y, d);
    end
  endtask

  initial begin
    while (!done && cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    acc_m[0] = 0; acc_m[1] = 0;
    rst = 1'b1; in_valid = 1'b0; in_chan = 1'b0; in_data = '0; freeze = 1'b0;
    repeat (3) @(negedge clk);
    // R7 reset state
    check(out_valid == 1'b0, "R7 valid", longint'(out_valid), 0);
    check(out_data == '0, "R7 data", longint'(out_data), 0);
    rst = 1'b0;

    // R2 first sample passes unchanged with a zero estimate
    step(1, 0, 5000, 0, "R2 first");
    check(last_y == 5000, "R2 zero estimate", last_y, 5000);
    step(1, 1, -3000, 0, "R5 right first");
    check(last_y == -3000, "R5 right independent", last_y, -3000);

    // R3 / R9 settling under constant DC on both channels
    for (int i = 0; i < 60; i++) begin
      step(1, 0, 5000, 0, "R3 left settle");
      step(1, 1, -3000, 0, "R3 right settle");
    end
    check(last_y > -200 && last_y <= 0, "R9 decay right", last_y, 0);
    step(1, 0, 5000, 0, "R9 left");
    check(last_y < 200 && last_y >= 0, "R9 decay left", last_y, 0);

    // R8 idle gap, then compare next sample against model
    for (int i = 0; i < 5; i++) step(0, 0, 123456, 0, "R8 idle");
    step(1, 0, 5000, 0, "R8 after idle");

    // R4 frozen: held offset applied to varying inputs
    for (int i = 0; i < 20; i++) step(1, i[0], longint'(i * 1000 - 7000), 1, "R4 frozen");
    step(1, 0, 0, 1, "R4 zero in");
    check(last_y == -(acc_m[0] >>> K), "R4 held offset", last_y, -(acc_m[0] >>> K));

    // R6 saturation at both limits
    for (int i = 0; i < 150; i++) begin
      step(1, 0, 8000000, 0, "R3 left high");
      step(1, 1, -8000000, 0, "R3 right low");
    end
    step(1, 0, MINV, 1, "R6 low");
    check(last_y == MINV, "R6 clamp min", last_y, MINV);
    step(1, 1, MAXV, 1, "R6 high");
    check(last_y == MAXV, "R6 clamp max", last_y, MAXV);

    // R5 right-only traffic leaves the left estimate where it was
    for (int i = 0; i < 30; i++) step(1, 1, 100, 0, "R5 right only");
    step(1, 0, 8000000, 1, "R5 left unchanged");

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      step(bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)),
           longint'($signed($urandom_range(0, 32'h00FF_FFFF) - 32'h0080_0000)) / 4,
           bit'($urandom_range(0, 4) == 0), "R2 R3 R4 random");
    end

    // R7 reset mid-run clears the estimates
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0; acc_m[0] = 0; acc_m[1] = 0;
    step(1, 1, 4242, 0, "R7 cleared");
    check(last_y == 4242, "R7 estimate zero", last_y, 4242);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule